// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counter channel of an interval timer. A neighbouring control block hands it a mode code, a decimal/binary choice and a starting value, and pulses a load strobe to commit them. The channel then counts on each cycle where its clock-enable input is high. Depending on the mode, it either waits for the gate input to be high or waits for a rising edge on the gate, and it shapes its output pin into a terminal-count flag, a one-shot, a rate pulse, a square wave or a strobe.

The live count, the output level and a count-loaded flag are visible at all times. A loaded value of zero stands for the full range: 65536 counts in binary and 10000 in decimal. Each count is two bytes. In decimal counting the four nibbles are BCD digits, with the least significant digit in bits 3:0.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is high, the count is 0 and the count-loaded flag is 0.
- R2: A load strobe captures the mode, the decimal flag and the value, and clears the loaded flag on the next clock. On that same clock the output moves to its initial level: low for mode 0, high for every other mode. The value reaches the count on the first clock with the enable high that follows the strobe, and the loaded flag then rises.
- R3: Mode 0 (code 000): each enabled clock decrements the count by one. When the count reaches 0 the output goes high and the count stops there until the next load.
- R4: Mode 1 (code 001): the output stays high until a rising gate edge arrives on or before an enabled clock. That clock reloads the count and drives the output low. The output returns high after N further enabled clocks. Gate edges that arrive while this countdown is running are ignored.
- R5: Mode 2 (code 010): the output goes low while the count is 1, and the count reloads on the next enabled clock, so the period is N enabled clocks. A low gate forces the output high on the next clock.
- R6: Mode 3 (code 011): the output toggles every time the count runs out, and the count reloads each time. For even N both halves last N/2 enabled clocks. For odd N the high half lasts (N+1)/2 and the low half lasts (N-1)/2.
- R7: In mode 3, once a count is loaded, the count bit 0 always reads 0.
- R8: Mode 4 (code 100): the output stays high until the count reaches 0. It is then low for one enabled clock and returns high, and the count does not reload.
- R9: Mode 5 (code 101): a rising gate edge starts the countdown, and a later fall of the gate does not stop it. At 0 the output is low for one enabled clock, and the count does not reload.
- R10: In modes 0, 2, 3 and 4 an enabled clock with the gate low leaves the count unchanged. In modes 1 and 5 the gate level does not stop a running count.
- R11: With the decimal flag set, each nibble counts 9 down to 0, and a borrow passes into the next nibble.
- R12: A loaded value of 0 acts as 65536 in binary and 10000 in decimal. The first decrement gives FFFF or 9999 respectively.
- R13: Mode codes 110 and 111 behave as modes 2 and 3.
- R14: The count changes only on clocks where the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one count per high cycle |
| gate | input | 1 | Gate input |
| mode_in | input | 3 | Mode code captured on load |
| bcd_in | input | 1 | 1 selects decimal counting |
| reload_in | input | 16 | Starting count captured on load |
| load | input | 1 | Commit strobe for mode, flag and value |
| out | output | 1 | Channel output pin |
| count | output | 16 | Live count |
| loaded | output | 1 | A count has been transferred |

## Verification
Most internal faults show up within one period of the programmed count. A wrong borrow or a wrong step size changes the live count on the very next enabled clock. A wrong reload value or a missing half-count hold in square-wave mode stretches or shortens the output phases, and this is visible at the first toggle. A lost trigger in the one-shot modes leaves the output high, and a trigger that is honoured during a countdown shows as a late edge. Measuring phase lengths in enabled clocks exposes each of these faults directly.

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         gate,
  input  logic [2:0]   mode_in,
  input  logic         bcd_in,
  input  logic [W-1:0] reload_in,
  input  logic         load,
  output logic         out,
  output logic [W-1:0] count,
  output logic         loaded
);

  logic [2:0]   mode_q;
  logic         bcd_q, out_q, loaded_q, pend_q, run_q, hold_q, trig_q, gate_q;
  logic [W-1:0] rld_q, cnt_q, nxt1, nxt2, rld_even;
  logic [2:0]   mode_eff;
  logic         trig_now;

  function automatic logic [W-1:0] dec1(input logic [W-1:0] v, input logic dec);
    logic [W-1:0] r;
    logic borrow;
    r = v - 1'b1;
    if (dec) begin
      r = v;
      borrow = 1'b1;
      for (int i = 0; i < DIGITS; i++) begin
        if (borrow) begin
          if (r[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
          else begin
            r[4*i +: 4] = r[4*i +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  assign mode_eff = (mode_in[2:1] == 2'b11) ? {1'b0, mode_in[1:0]} : mode_in;
  assign nxt1     = dec1(cnt_q, bcd_q);
  assign nxt2     = dec1(nxt1, bcd_q);
  assign rld_even = {rld_q[W-1:1], 1'b0};
  assign trig_now = trig_q | (gate & ~gate_q);
  assign out      = out_q;
  assign count    = cnt_q;
  assign loaded   = loaded_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; bcd_q <= 1'b0; rld_q <= '0; cnt_q <= '0;
      out_q <= 1'b1; loaded_q <= 1'b0; pend_q <= 1'b0; run_q <= 1'b0;
      hold_q <= 1'b0; trig_q <= 1'b0; gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (load) begin
        mode_q <= mode_eff; bcd_q <= bcd_in; rld_q <= reload_in;
        pend_q <= 1'b1; loaded_q <= 1'b0; run_q <= 1'b0; hold_q <= 1'b0; trig_q <= 1'b0;
        out_q <= (mode_eff != 3'd0);
      end else begin
        if (gate & ~gate_q) trig_q <= 1'b1;
        if (mode_q == 3'd2 && !gate) out_q <= 1'b1;
        if (tick) begin
          trig_q <= 1'b0;
          case (mode_q)
            3'd0, 3'd4: begin
              if (mode_q == 3'd4 && !out_q) out_q <= 1'b1;
              if (pend_q) begin
                cnt_q <= rld_q; pend_q <= 1'b0; loaded_q <= 1'b1; run_q <= 1'b1;
              end else if (run_q && gate) begin
                cnt_q <= nxt1;
                if (nxt1 == '0) begin
                  run_q <= 1'b0;
                  out_q <= (mode_q == 3'd0);
                end
              end
            end
            3'd1, 3'd5: begin
              if (mode_q == 3'd5 && !out_q) out_q <= 1'b1;
              if (pend_q) begin
                cnt_q <= rld_q; pend_q <= 1'b0; loaded_q <= 1'b1;
              end
              if (run_q) begin
                cnt_q <= nxt1;
                if (nxt1 == '0) begin
                  run_q <= 1'b0;
                  out_q <= (mode_q == 3'd1);
                end
              end else if ((loaded_q || pend_q) && trig_now) begin
                cnt_q <= rld_q; run_q <= 1'b1;
                if (mode_q == 3'd1) out_q <= 1'b0;
              end
            end
            3'd2: begin
              if (pend_q) begin
                cnt_q <= rld_q; pend_q <= 1'b0; loaded_q <= 1'b1; out_q <= 1'b1;
              end else if (loaded_q && gate) begin
                if (nxt1 == '0) begin
                  cnt_q <= rld_q; out_q <= 1'b1;
                end else begin
                  cnt_q <= nxt1;
                  if (nxt1 == W'(1)) out_q <= 1'b0;
                end
              end
            end
            default: begin
              if (pend_q) begin
                cnt_q <= rld_even; pend_q <= 1'b0; loaded_q <= 1'b1;
                out_q <= 1'b1; hold_q <= rld_q[0];
              end else if (loaded_q && gate) begin
                if (hold_q) hold_q <= 1'b0;
                else if (nxt2 == '0) begin
                  cnt_q <= rld_even; out_q <= ~out_q; hold_q <= rld_q[0] & ~out_q;
                end else cnt_q <= nxt2;
              end
            end
          endcase
        end
      end
    end
  end

endmodule

module pit_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load,
  input logic        tick,
  input logic        gate,
  input logic [2:0]  mode_in,
  input logic [2:0]  mode_q,
  input logic        pend_q,
  input logic        out,
  input logic [15:0] count,
  input logic        loaded
);
  // R2
  load_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !loaded);
  // R2
  load_mode0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode_in == 3'd0) |=> !out);
  // R14
  count_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(count));
  // R5
  rate_gate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && mode_q == 3'd2 && !gate) |=> out);
  // R7
  square_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd3 && loaded) |-> !count[0]);
  // R10
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gate && !load && !pend_q &&
     (mode_q == 3'd0 || mode_q == 3'd2 || mode_q == 3'd3 || mode_q == 3'd4))
    |=> $stable(count));
endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .tick(tick), .gate(gate),
  .mode_in(mode_in), .mode_q(mode_q), .pend_q(pend_q),
  .out(out), .count(count), .loaded(loaded)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, gate = 1'b0, bcd_in = 1'b0, load = 1'b0;
  logic [2:0]  mode_in = 3'd0;
  logic [15:0] reload_in = '0;
  logic        out, loaded;
  logic [15:0] count;
  int checks = 0, fails = 0;

  pit_channel u_pit_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .mode_in(mode_in),
    .bcd_in(bcd_in), .reload_in(reload_in), .load(load),
    .out(out), .count(count), .loaded(loaded)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    tick = t;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic do_load(input logic [2:0] m, input logic b, input logic [15:0] v);
    load = 1'b1; mode_in = m; bcd_in = b; reload_in = v;
    cyc(1'b0);
    load = 1'b0;
  endtask

  task automatic phase(output int n);
    logic v;
    v = out;
    n = 0;
    while (out == v && n < 70000) begin
      cyc(1'b1);
      n++;
    end
  endtask

  task automatic t_reset;
    check("R1 out", out, 1);
    check("R1 count", count, 0);
    check("R1 loaded", loaded, 0);
  endtask

  task automatic t_mode0;
    gate = 1'b1;
    do_load(3'd0, 1'b0, 16'd3);
    check("R2 out initial low", out, 0);
    check("R2 loaded clear", loaded, 0);
    cyc(1'b1);
    check("R2 transfer", count, 3);
    check("R2 loaded set", loaded, 1);
    ticks(2);
    check("R3 count", count, 1);
    check("R3 out still low", out, 0);
    cyc(1'b1);
    check("R3 out high at zero", out, 1);
    check("R3 count zero", count, 0);
    cyc(1'b1);
    check("R3 stays", {count, 15'd0, out}, {16'd0, 15'd0, 1'b1});
  endtask

  task automatic t_gate_tick;
    gate = 1'b1;
    do_load(3'd0, 1'b0, 16'd5);
    cyc(1'b1);
    gate = 1'b0;
    ticks(3);
    check("R10 gated hold", count, 5);
    gate = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0);
    check("R14 no tick", count, 5);
    cyc(1'b1);
    check("R10 resumes", count, 4);
  endtask

  task automatic t_mode1;
    gate = 1'b0;
    do_load(3'd1, 1'b0, 16'd4);
    check("R2 mode1 initial high", out, 1);
    cyc(1'b1);
    ticks(2);
    check("R4 waits trigger", {count, 15'd0, out}, {16'd4, 15'd0, 1'b1});
    gate = 1'b1;
    cyc(1'b1);
    check("R4 triggered low", out, 0);
    gate = 1'b0;
    ticks(3);
    check("R10 mode1 runs gate low", count, 1);
    check("R4 still low", out, 0);
    gate = 1'b1;
    cyc(1'b1);
    check("R4 retrigger ignored", {count, 15'd0, out}, {16'd0, 15'd0, 1'b1});
  endtask

  task automatic t_mode2;
    gate = 1'b1;
    do_load(3'd2, 1'b0, 16'd3);
    cyc(1'b1);
    cyc(1'b1);
    check("R5 count2 high", {count, 15'd0, out}, {16'd2, 15'd0, 1'b1});
    cyc(1'b1);
    check("R5 low at one", out, 0);
    cyc(1'b1);
    check("R5 reload high", {count, 15'd0, out}, {16'd3, 15'd0, 1'b1});
    ticks(2);
    check("R5 low again", out, 0);
    gate = 1'b0;
    cyc(1'b0);
    check("R5 gate low forces high", out, 1);
    cyc(1'b1);
    check("R10 mode2 halted", count, 1);
    gate = 1'b1;
  endtask

  task automatic t_mode3;
    int n;
    gate = 1'b1;
    do_load(3'd3, 1'b0, 16'd4);
    cyc(1'b1);
    phase(n); check("R6 even high half", n, 2);
    phase(n); check("R6 even low half", n, 2);
    do_load(3'd3, 1'b0, 16'd5);
    cyc(1'b1);
    check("R7 odd loads even", count, 4);
    phase(n); check("R6 odd high half", n, 3);
    phase(n); check("R6 odd low half", n, 2);
    phase(n); check("R6 odd high again", n, 3);
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1);
      check("R7 even readback", count[0], 0);
    end
  endtask

  task automatic t_mode4;
    gate = 1'b1;
    do_load(3'd4, 1'b0, 16'd2);
    check("R8 initial high", out, 1);
    cyc(1'b1);
    cyc(1'b1);
    check("R8 high before zero", out, 1);
    cyc(1'b1);
    check("R8 pulse low", {count, 15'd0, out}, {16'd0, 15'd0, 1'b0});
    cyc(1'b1);
    check("R8 back high", out, 1);
    cyc(1'b1);
    check("R8 no reload", {count, 15'd0, out}, {16'd0, 15'd0, 1'b1});
  endtask

  task automatic t_mode5;
    gate = 1'b0;
    do_load(3'd5, 1'b0, 16'd2);
    cyc(1'b1);
    cyc(1'b1);
    check("R9 waits trigger", count, 2);
    gate = 1'b1;
    cyc(1'b1);
    gate = 1'b0;
    cyc(1'b1);
    check("R9 runs after gate fall", {count, 15'd0, out}, {16'd1, 15'd0, 1'b1});
    cyc(1'b1);
    check("R9 pulse low", {count, 15'd0, out}, {16'd0, 15'd0, 1'b0});
    cyc(1'b1);
    check("R9 back high no reload", {count, 15'd0, out}, {16'd0, 15'd0, 1'b1});
  endtask

  task automatic t_bcd;
    gate = 1'b1;
    do_load(3'd0, 1'b1, 16'h0010);
    cyc(1'b1);
    cyc(1'b1);
    check("R11 borrow to digit", count, 16'h0009);
    do_load(3'd2, 1'b1, 16'h0000);
    cyc(1'b1);
    cyc(1'b1);
    check("R12 bcd zero is 10000", count, 16'h9999);
    do_load(3'd2, 1'b0, 16'h0000);
    cyc(1'b1);
    cyc(1'b1);
    check("R12 binary zero", count, 16'hFFFF);
  endtask

  task automatic t_bcd_full;
    int n;
    gate = 1'b1;
    do_load(3'd0, 1'b1, 16'h0000);
    cyc(1'b1);
    phase(n);
    check("R12 bcd full span", n, 10000);
  endtask

  task automatic t_alias;
    int n;
    gate = 1'b1;
    do_load(3'd6, 1'b0, 16'd3);
    cyc(1'b1);
    ticks(2);
    check("R13 code 110 rate low", {count, 15'd0, out}, {16'd1, 15'd0, 1'b0});
    do_load(3'd7, 1'b0, 16'd4);
    cyc(1'b1);
    phase(n);
    check("R13 code 111 square half", n, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_gate_tick();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_bcd();
    t_bcd_full();
    t_alias();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule